// File: doc/BRIEF.md
# Vector Length Setting Unit

This unit takes a 12-bit length-control field from an instruction prefix and updates two pieces of architectural state: the maximum vector length and the current vector length. One field carries three things: a 5-bit immediate that becomes the new maximum, an optional source register whose value requests a length, and an optional destination register that receives the resulting length.

The top bit of the field picks one of two register-naming schemes. In the compact scheme, two 3-bit specifiers select registers 8 to 15, one as a source and one as a destination. In the wide scheme, a single 5-bit register number is used. A flag bit decides whether that register is the destination or the source. One encoding in the wide scheme is reserved. When the unit sees it, it raises an illegal-instruction pulse and changes no state.

The unit works on one request per cycle. The register-file read index is driven combinationally from the field, and the read data is sampled at the same clock edge as the request. The new lengths, the write-back request and the illegal pulse all appear as registered outputs in the following cycle.

Top module: `vlset_unit`

## Requirements
- R1: While `rst` is high, and after it is released with no request, `vl`, `mvl`, `wb_en` and `illegal` are all 0.
- R2: A request with field bit 11 = 0 and bits 10:0 all zero leaves `vl` and `mvl` unchanged and produces no write-back.
- R3: With bit 11 = 0, a nonzero immediate (bits 10:6), compact destination bits 5:3 = 0 and compact source bits 2:0 = 0, the unit sets `mvl` and `vl` to the immediate and produces no write-back.
- R4: With bit 11 = 0 and a nonzero compact source s (bits 2:0), `rf_rd_idx` equals s+8 in the request cycle. The new `vl` is the smaller of the read data and the immediate, and `mvl` becomes the immediate.
- R5: With bit 11 = 0 and a nonzero compact destination d (bits 5:3), the cycle after the request has `wb_en` = 1, `wb_idx` = d+8 and `wb_data` = the new `vl`, zero-extended.
- R6: With bit 11 = 1 and flag bit 5 = 0, `mvl` and `vl` become the immediate. If the register number r (bits 4:0) is nonzero, the write-back goes to register r; if r = 0, there is no write-back.
- R7: With bit 11 = 1, flag bit 5 = 1 and r nonzero, `rf_rd_idx` = r and `vl` becomes the smaller of the read data and the immediate. There is no write-back.
- R8: With bit 11 = 1, bit 5 = 1 and r = 0, `illegal` is high for exactly the next cycle, and there is no write-back and no change to `vl` or `mvl`.
- R9: In a cycle with `req_valid` low, the next cycle shows no write-back, no illegal pulse and no state change.
- R10: The minimum is an unsigned comparison over the full register width. A read value with any bit at or above bit 5 set yields the immediate.
- R11: All results appear one cycle after the request, and `wb_en` and `illegal` are single-cycle pulses per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one request per cycle |
| vltype | input | 12 | Length-control field |
| rf_rd_idx | output | 5 | Register-file read index (combinational) |
| rf_rd_data | input | XLEN | Register-file read data for `rf_rd_idx` |
| wb_en | output | 1 | Write-back enable pulse |
| wb_idx | output | 5 | Write-back destination register |
| wb_data | output | XLEN | Write-back value (zero-extended `vl`) |
| illegal | output | 1 | Reserved-encoding pulse |
| vl | output | 5 | Current vector length |
| mvl | output | 5 | Maximum vector length |

## Verification
Requests are issued in both naming schemes. Source registers are chosen with values below the immediate, above it, equal to zero, and with high bits set, which separates a correct unsigned full-width minimum from one that is truncated or signed. The no-change field, a zero immediate with a destination, and the zero-register case with the flag both clear and set show whether the unit tells the no-op, write-back-suppressed and reserved cases apart. Idle cycles placed between requests confirm that the pulses last one cycle and that state holds.

// File: rtl/vlset_pkg.sv
package vlset_pkg;
  localparam int FIELD_W  = 12;
  localparam int IMM_W    = 5;
  localparam int RIDX_W   = 5;
  localparam int CREG_W   = 3;
  localparam int CREG_BASE = 8;
  localparam int MODE_BIT = 11;
  localparam int IMM_LSB  = 6;
  localparam int FLAG_BIT = 5;

  typedef enum logic [1:0] {
    CASE_NOP  = 2'd0,
    CASE_SET  = 2'd1,
    CASE_RSVD = 2'd2
  } vlset_case_e;

  typedef struct packed {
    logic              upd;
    logic              illegal;
    logic              use_src;
    logic [RIDX_W-1:0] src;
    logic              wb;
    logic [RIDX_W-1:0] dst;
    logic [IMM_W-1:0]  imm;
  } vlset_cmd_t;
endpackage

// File: rtl/vlset_decode.sv
module vlset_decode
  import vlset_pkg::*;
(
  input  logic               valid,
  input  logic [FIELD_W-1:0] field,
  output vlset_cmd_t         cmd,
  output logic [RIDX_W-1:0]  rd_idx
);
  logic [IMM_W-1:0]  imm_f;
  logic [CREG_W-1:0] c_dst, c_src;
  logic              flag_f;
  logic [RIDX_W-1:0] wide_r;
  vlset_case_e       kind;
  vlset_cmd_t        raw;

  assign imm_f  = field[IMM_LSB +: IMM_W];
  assign c_dst  = field[CREG_W +: CREG_W];
  assign c_src  = field[0 +: CREG_W];
  assign flag_f = field[FLAG_BIT];
  assign wide_r = field[0 +: RIDX_W];

  always_comb begin
    raw     = '0;
    raw.imm = imm_f;
    kind    = CASE_SET;
    if (!field[MODE_BIT]) begin
      if (imm_f == '0 && c_dst == '0 && c_src == '0) begin
        kind = CASE_NOP;
      end else begin
        raw.use_src = (c_src != '0);
        raw.src     = RIDX_W'(CREG_BASE) + RIDX_W'(c_src);
        raw.wb      = (c_dst != '0);
        raw.dst     = RIDX_W'(CREG_BASE) + RIDX_W'(c_dst);
      end
    end else if (flag_f) begin
      if (wide_r == '0) begin
        kind = CASE_RSVD;
      end else begin
        raw.use_src = 1'b1;
        raw.src     = wide_r;
      end
    end else begin
      raw.wb  = (wide_r != '0);
      raw.dst = wide_r;
    end
    raw.upd     = (kind == CASE_SET);
    raw.illegal = (kind == CASE_RSVD);
  end

  always_comb begin
    cmd         = raw;
    cmd.upd     = raw.upd && valid;
    cmd.illegal = raw.illegal && valid;
    cmd.wb      = raw.wb && raw.upd && valid;
    cmd.use_src = raw.use_src && raw.upd;
  end

  assign rd_idx = cmd.use_src ? raw.src : '0;
endmodule

// File: rtl/vlset_minsel.sv
module vlset_minsel
  import vlset_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [IMM_W-1:0] imm,
  input  logic             use_src,
  input  logic [XLEN-1:0]  rdata,
  output logic [IMM_W-1:0] vl_next
);
  logic below;

  generate
    if (XLEN > IMM_W) begin : g_wide
      logic hi_nz;
      assign hi_nz = |rdata[XLEN-1:IMM_W];
      assign below = !hi_nz && (rdata[IMM_W-1:0] < imm);
    end else begin : g_narrow
      assign below = (IMM_W'(rdata) < imm);
    end
  endgenerate

  assign vl_next = (use_src && below) ? rdata[IMM_W-1:0] : imm;
endmodule

// File: rtl/vlset_state.sv
module vlset_state
  import vlset_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  vlset_cmd_t        cmd,
  input  logic [IMM_W-1:0]  vl_next,
  output logic [IMM_W-1:0]  vl_q,
  output logic [IMM_W-1:0]  mvl_q,
  output logic              wb_en_q,
  output logic [RIDX_W-1:0] wb_idx_q,
  output logic [XLEN-1:0]   wb_data_q,
  output logic              illegal_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      vl_q      <= '0;
      mvl_q     <= '0;
      wb_en_q   <= 1'b0;
      wb_idx_q  <= '0;
      wb_data_q <= '0;
      illegal_q <= 1'b0;
    end else begin
      wb_en_q   <= cmd.wb;
      illegal_q <= cmd.illegal;
      wb_idx_q  <= cmd.wb ? cmd.dst : '0;
      wb_data_q <= cmd.wb ? XLEN'(vl_next) : '0;
      if (cmd.upd) begin
        mvl_q <= cmd.imm;
        vl_q  <= vl_next;
      end
    end
  end
endmodule

// File: rtl/vlset_unit.sv
module vlset_unit
  import vlset_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic [FIELD_W-1:0]  vltype,
  output logic [RIDX_W-1:0]   rf_rd_idx,
  input  logic [XLEN-1:0]     rf_rd_data,
  output logic                wb_en,
  output logic [RIDX_W-1:0]   wb_idx,
  output logic [XLEN-1:0]     wb_data,
  output logic                illegal,
  output logic [IMM_W-1:0]    vl,
  output logic [IMM_W-1:0]    mvl
);
  vlset_cmd_t       cmd;
  logic [IMM_W-1:0] vl_next;

  vlset_decode u_dec (
    .valid  (req_valid),
    .field  (vltype),
    .cmd    (cmd),
    .rd_idx (rf_rd_idx)
  );

  vlset_minsel #(.XLEN(XLEN)) u_min (
    .imm     (cmd.imm),
    .use_src (cmd.use_src),
    .rdata   (rf_rd_data),
    .vl_next (vl_next)
  );

  vlset_state #(.XLEN(XLEN)) u_st (
    .clk       (clk),
    .rst       (rst),
    .cmd       (cmd),
    .vl_next   (vl_next),
    .vl_q      (vl),
    .mvl_q     (mvl),
    .wb_en_q   (wb_en),
    .wb_idx_q  (wb_idx),
    .wb_data_q (wb_data),
    .illegal_q (illegal)
  );
endmodule

// File: rtl/vlset_unit_chk.sv
module vlset_unit_chk #(
  parameter int XLEN = 32
) (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic [11:0] vltype,
  input logic [4:0]  rf_rd_idx,
  input logic        wb_en,
  input logic [4:0]  wb_idx,
  input logic [XLEN-1:0] wb_data,
  input logic        illegal,
  input logic [4:0]  vl,
  input logic [4:0]  mvl
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!wb_en && !illegal)); // R9
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> ($stable(vl) && $stable(mvl))); // R9
  AST_RSVD_HOLDS: assert property (@(posedge clk) disable iff (rst)
    illegal |-> ($stable(vl) && $stable(mvl) && !wb_en)); // R8
  AST_VL_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    vl <= mvl); // R4
  AST_WB_MATCHES_VL: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> (wb_data == XLEN'(vl))); // R5
  AST_WB_NOT_X0: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> (wb_idx != 5'd0)); // R6
  AST_COMPACT_SRC: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !vltype[11] && vltype[2:0] != 3'd0) |-> (rf_rd_idx == {2'b01, vltype[2:0]})); // R4
  AST_NOP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (req_valid && vltype == 12'h000) |=> ($stable(vl) && $stable(mvl) && !wb_en)); // R2
endmodule

bind vlset_unit vlset_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .vltype(vltype),
  .rf_rd_idx(rf_rd_idx), .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data),
  .illegal(illegal), .vl(vl), .mvl(mvl)
);

// File: tb/tb_vlset_unit.sv
`timescale 1ns/1ps
module tb_vlset_unit;
  localparam int XLEN = 32;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            req_valid = 1'b0;
  logic [11:0]     vltype = '0;
  logic [4:0]      rf_rd_idx;
  logic [XLEN-1:0] rf_rd_data;
  logic            wb_en, illegal;
  logic [4:0]      wb_idx, vl, mvl;
  logic [XLEN-1:0] wb_data;

  logic [XLEN-1:0] regs [32];
  int n_checks = 0;
  int n_err = 0;
  int e_vl = 0;
  int e_mvl = 0;

  always #2 clk = ~clk;

  assign rf_rd_data = regs[rf_rd_idx];

  vlset_unit #(.XLEN(XLEN)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .vltype(vltype),
    .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data),
    .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data),
    .illegal(illegal), .vl(vl), .mvl(mvl)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [11:0] f0(input int imm, input int d, input int s);
    return {1'b0, 5'(imm), 3'(d), 3'(s)};
  endfunction

  function automatic logic [11:0] f1(input int imm, input bit flag, input int r);
    return {1'b1, 5'(imm), flag, 5'(r)};
  endfunction

  task automatic step(input bit v, input logic [11:0] f, input string req);
    int imm, src, dst, nvl, cd, cs, r;
    bit upd, ill, wb;
    longint unsigned rv;
    imm = int'(f[10:6]);
    src = -1; dst = 0; upd = 0; ill = 0; wb = 0;
    cd = int'(f[5:3]); cs = int'(f[2:0]); r = int'(f[4:0]);
    if (!f[11]) begin
      if (!(imm == 0 && cd == 0 && cs == 0)) begin
        upd = 1;
        if (cs != 0) src = cs + 8;
        if (cd != 0) begin wb = 1; dst = cd + 8; end
      end
    end else if (!f[5]) begin
      upd = 1;
      if (r != 0) begin wb = 1; dst = r; end
    end else if (r == 0) begin
      ill = 1;
    end else begin
      upd = 1; src = r;
    end
    if (!v) begin upd = 0; ill = 0; wb = 0; end
    nvl = imm;
    if (src >= 0) begin
      rv = longint'(regs[src]);
      if (rv < longint'(imm)) nvl = int'(rv);
    end
    @(negedge clk);
    req_valid = v;
    vltype = f;
    #1;
    if (upd && src >= 0) chk(rf_rd_idx == 5'(src), req, "rd_idx", rf_rd_idx, src);
    @(posedge clk);
    #1;
    if (upd) begin e_vl = nvl; e_mvl = imm; end
    chk(vl == 5'(e_vl), req, "vl", vl, e_vl);
    chk(mvl == 5'(e_mvl), req, "mvl", mvl, e_mvl);
    chk(wb_en == wb, req, "wb_en", wb_en, wb);
    chk(illegal == ill, req, "illegal", illegal, ill);
    if (wb) begin
      chk(wb_idx == 5'(dst), req, "wb_idx", wb_idx, dst);
      chk(wb_data == XLEN'(nvl), req, "wb_data", wb_data, nvl);
    end
  endtask

  task automatic run_tests;
    for (int i = 0; i < 32; i++) regs[i] = XLEN'(i * 1000 + 40);
    regs[9]  = 32'h8000_0002;
    regs[10] = 32'd4;
    regs[12] = 32'd0;
    regs[15] = 32'd31;
    regs[20] = 32'd7;
    regs[8]  = 32'd100;
    regs[11] = 32'h0000_0020;
    repeat (3) @(posedge clk);
    #1;
    chk(vl == 0 && mvl == 0, "R1", "state in reset", {vl, mvl}, 0);
    chk(!wb_en && !illegal, "R1", "pulses in reset", {wb_en, illegal}, 0);
    @(negedge clk);
    rst = 1'b0;
    step(0, 12'h000, "R1");
    step(0, f1(20, 0, 0), "R9");
    step(1, f1(20, 0, 0), "R6");
    step(1, 12'h000, "R2");
    step(0, 12'h000, "R11");
    step(1, f0(13, 0, 0), "R3");
    step(1, f0(17, 0, 2), "R4");
    step(1, f0(17, 0, 1), "R10");
    step(1, f0(6, 0, 7), "R4");
    step(1, f0(22, 0, 4), "R4");
    step(1, f0(9, 0, 3), "R10");
    step(1, f0(9, 3, 0), "R5");
    step(0, f0(9, 3, 0), "R11");
    step(1, f0(25, 7, 2), "R5");
    step(1, f0(0, 1, 0), "R5");
    step(1, f1(30, 0, 31), "R6");
    step(1, f1(10, 1, 20), "R7");
    step(1, f1(31, 1, 8), "R7");
    step(1, f1(3, 1, 9), "R10");
    step(1, f1(22, 1, 0), "R8");
    step(0, f1(22, 1, 0), "R11");
    step(1, f1(5, 1, 0), "R8");
    step(1, f0(12, 5, 6), "R5");
    step(0, 12'h000, "R9");
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (200000) @(posedge clk);
        chk(0, "WD", "watchdog expired", 0, 1);
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule